// File: doc/BRIEF.md
# Self-timed byte-write controller for a parallel nonvolatile memory

This block is the control core of a byte-wide nonvolatile memory, modelled as synchronous logic running on a system clock. A host drives it with three active-low strobes (chip select, output enable and write strobe), an address bus and a data bus. It answers reads from an on-chip register array. A write is self-timed: the controller captures address and data, then holds an active-low busy indication for a programmed number of clock cycles. The array is updated when that time runs out. During that time the host can poll the byte it just wrote to learn when the write is done.

Three flag inputs model conditions that would need a high voltage or an analog detector on a real part. One opens a small identification row at the top 32 addresses. One turns a write strobe into a whole-array clear. One reports that the supply is too low to start a write. All strobes and flags are passed through a two-flop synchronizer before they are used. Narrow write-strobe glitches are filtered out.

Top module: `eeprom_write_engine`

## Requirements
- R1: With chip select low, output enable low and write strobe high, `dout_en` is 1 and `dout` carries the stored byte at `addr`. A change on any strobe or flag takes effect two clock samples after the pin changes; `addr` acts at once.
- R2: While chip select is high, `dout_en` is 0 and `dout` is 0x00, whatever output enable does.
- R3: A write strobe given while output enable is low starts nothing: `ready` stays 1 and the array is unchanged.
- R4: `ready` goes to 0 once a write qualifies. It returns to 1 after exactly the write-time cycle count, counted from the clock on which the data is captured. The new byte becomes readable at that same point.
- R5: The address is taken at the point where chip select and write strobe are first both low. The data is taken at the point where either of them rises again. Later changes on either bus do not alter the write.
- R6: A write strobe whose combined low time lasts fewer than `GLITCH_MIN` clock samples starts nothing. A low time of exactly `GLITCH_MIN` samples performs the write.
- R7: While a byte write is being timed, a read of the address being written returns 0x80 if the new bit 7 is 0 and 0x00 if it is 1; bits 6..0 read as zero. Once `ready` returns, the true byte is read.
- R8: The write time is `FAST_CYCLES` when `FAST_VARIANT` is 1 and `SLOW_CYCLES` otherwise.
- R9: While `id_hv` is 1, the 32 addresses whose upper address bits are all ones read and write a separate identification row. With `id_hv` at 0, the same addresses reach the main array.
- R10: A write strobe given with `clr_hv` at 1 sets every main-array byte to 0xFF after `CLEAR_CYCLES` busy cycles. It leaves the identification row unchanged.
- R11: While `vcc_low` is 1, no write or clear starts: `ready` stays 1 and nothing changes.
- R12: A write strobe given while `ready` is 0 is ignored. The byte it targeted keeps its old value, and the running write completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; array powers up as all ones |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| id_hv | input | 1 | Identification row select (stands for a high voltage on an address pin) |
| clr_hv | input | 1 | Clear select (stands for a high voltage on output enable) |
| vcc_low | input | 1 | Supply below the write threshold |
| dout | output | 8 | Read data, 0x00 when not driving |
| dout_en | output | 1 | Read data is being driven |
| ready | output | 1 | 1 when idle; 0 while a write or clear is timed (active-low busy) |

## Verification
The bench builds the block with an 8-bit address, a glitch threshold of 3 samples, the fast write variant at 16 cycles (slow 40) and a clear time of 60 cycles. With those values, a full clear and dozens of writes fit in a few thousand cycles. The 32-byte identification row sits at 0xE0..0xFF, where a short walk reaches it. The threshold of 3 lets the bench place pulses of 2 and 3 samples on either side of the filter boundary. The short write time lets polling reads and strobes given while busy land inside the timed window.

// File: rtl/eew_pkg.sv
package eew_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_HOLD = 2'd2,
    ST_PROG = 2'd3
  } eew_state_e;

  // Status byte returned by a poll of the byte being written.
  function automatic logic [7:0] poll_byte(input logic [7:0] data);
    return {~data[7], 7'b000_0000};
  endfunction

  // Busy length of the timed phase for either kind of operation.
  function automatic int unsigned busy_len(input logic is_clear,
                                           input int unsigned wr_len,
                                           input int unsigned clr_len);
    return is_clear ? clr_len : wr_len;
  endfunction

endpackage

// File: rtl/eew_sync.sv
module eew_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/eew_ctrl.sv
module eew_ctrl
  import eew_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int GLITCH_MIN   = 2,
  parameter int WR_CYCLES    = 100000,
  parameter int CLEAR_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              oe_s,
  input  logic              we_s,
  input  logic              id_s,
  input  logic              clr_s,
  input  logic              vlow_s,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output eew_state_e        state,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [7:0]        lat_data,
  output logic              lat_id,
  output logic              lat_clr,
  output logic              wr_start,
  output logic              wr_qualify,
  output logic              data_latch,
  output logic              commit
);

  localparam int CNT_MAX = (CLEAR_CYCLES > WR_CYCLES) ? CLEAR_CYCLES : WR_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] GL_LAST  = CNT_W'(GLITCH_MIN - 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(busy_len(1'b0, WR_CYCLES, CLEAR_CYCLES) - 1);
  localparam logic [CNT_W-1:0] CLR_LAST = CNT_W'(busy_len(1'b1, WR_CYCLES, CLEAR_CYCLES) - 1);

  logic [CNT_W-1:0] cnt;
  logic             wr_low, wr_low_q, wr_fall, permit;
  logic [CNT_W-1:0] prog_last;

  always_comb begin
    wr_low     = ~ce_s & ~we_s;
    wr_fall    = wr_low & ~wr_low_q;
    permit     = ~vlow_s & (oe_s | clr_s);
    wr_start   = (state == ST_IDLE) & wr_fall & permit;
    wr_qualify = ((state == ST_ARM) & wr_low & (cnt == GL_LAST)) |
                 ((GLITCH_MIN <= 1) & wr_start);
    data_latch = (state == ST_HOLD) & ~wr_low;
    prog_last  = lat_clr ? CLR_LAST : WR_LAST;
    commit     = (state == ST_PROG) & (cnt == prog_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      wr_low_q <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
      lat_id   <= 1'b0;
      lat_clr  <= 1'b0;
    end else begin
      wr_low_q <= wr_low;
      case (state)
        ST_IDLE: begin
          if (wr_start) begin
            lat_addr <= addr;
            lat_id   <= id_s;
            lat_clr  <= clr_s;
            cnt      <= CNT_W'(1);
            if (wr_qualify) state <= ST_HOLD;
            else            state <= ST_ARM;
          end
        end
        ST_ARM: begin
          if (!wr_low) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
            if (wr_qualify) state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (data_latch) begin
            lat_data <= din;
            cnt      <= '0;
            state    <= ST_PROG;
          end
        end
        default: begin
          if (commit) state <= ST_IDLE;
          else        cnt   <= cnt + CNT_W'(1);
        end
      endcase
    end
  end

endmodule

// File: rtl/eew_store.sv
module eew_store
  import eew_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int ID_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [7:0]        lat_data,
  input  logic              lat_id,
  input  logic              lat_clr,
  input  logic              poll_active,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              id_s,
  output logic [7:0]        dout
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int ID_AW = $clog2(ID_BYTES);

  logic [7:0] main_mem [DEPTH];
  logic [7:0] id_mem   [ID_BYTES];
  logic       wr_id, rd_id;

  function automatic logic in_top(input logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:ID_AW];
  endfunction

  assign wr_id = lat_id & in_top(lat_addr);
  assign rd_id = id_s & in_top(rd_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)    main_mem[i] <= 8'hFF;
      for (int j = 0; j < ID_BYTES; j++) id_mem[j]   <= 8'hFF;
    end else if (commit) begin
      if (lat_clr) begin
        for (int i = 0; i < DEPTH; i++) main_mem[i] <= 8'hFF;
      end else if (wr_id) begin
        id_mem[lat_addr[ID_AW-1:0]] <= lat_data;
      end else begin
        main_mem[lat_addr] <= lat_data;
      end
    end
  end

  always_comb begin
    dout = 8'h00;
    if (rd_en) begin
      if (poll_active && (rd_addr == lat_addr) && (rd_id == wr_id))
        dout = poll_byte(lat_data);
      else if (rd_id)
        dout = id_mem[rd_addr[ID_AW-1:0]];
      else
        dout = main_mem[rd_addr];
    end
  end

endmodule

// File: rtl/eeprom_write_engine.sv
module eeprom_write_engine
  import eew_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int GLITCH_MIN   = 2,
  parameter int SLOW_CYCLES  = 100000,
  parameter int FAST_CYCLES  = 20000,
  parameter bit FAST_VARIANT = 1'b0,
  parameter int CLEAR_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              id_hv,
  input  logic              clr_hv,
  input  logic              vcc_low,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              ready
);

  localparam int WR_CYCLES = FAST_VARIANT ? FAST_CYCLES : SLOW_CYCLES;
  localparam int N_SYNC    = 6;
  localparam logic [N_SYNC-1:0] SYNC_IDLE = 6'b111_000;

  logic [N_SYNC-1:0] raw_ctl, syn_ctl;
  logic ce_s, oe_s, we_s, id_s, clr_s, vlow_s;

  eew_state_e        state;
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        lat_data;
  logic              lat_id, lat_clr;
  logic              wr_start, wr_qualify, data_latch, commit;
  logic              rd_en, poll_active;

  assign raw_ctl = {ce_n, oe_n, we_n, id_hv, clr_hv, vcc_low};

  eew_sync #(.W(N_SYNC), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(syn_ctl)
  );

  assign {ce_s, oe_s, we_s, id_s, clr_s, vlow_s} = syn_ctl;

  eew_ctrl #(
    .ADDR_W(ADDR_W), .GLITCH_MIN(GLITCH_MIN),
    .WR_CYCLES(WR_CYCLES), .CLEAR_CYCLES(CLEAR_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
    .id_s(id_s), .clr_s(clr_s), .vlow_s(vlow_s),
    .addr(addr), .din(din),
    .state(state), .lat_addr(lat_addr), .lat_data(lat_data),
    .lat_id(lat_id), .lat_clr(lat_clr),
    .wr_start(wr_start), .wr_qualify(wr_qualify),
    .data_latch(data_latch), .commit(commit)
  );

  assign rd_en       = ~ce_s & ~oe_s & we_s;
  assign poll_active = (state == ST_PROG) & ~lat_clr;

  eew_store #(.ADDR_W(ADDR_W), .ID_BYTES(32)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .lat_addr(lat_addr), .lat_data(lat_data),
    .lat_id(lat_id), .lat_clr(lat_clr),
    .poll_active(poll_active), .rd_en(rd_en),
    .rd_addr(addr), .id_s(id_s), .dout(dout)
  );

  assign dout_en = rd_en;
  assign ready   = (state == ST_IDLE) | (state == ST_ARM);

endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              wr_qualify,
  input logic              data_latch,
  input logic              commit,
  input logic [ADDR_W-1:0] lat_addr,
  input logic [7:0]        lat_data,
  input logic [7:0]        din
);

  AST_QUALIFY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_qualify |=> !ready);  // R4

  AST_COMMIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ready);  // R4

  AST_BUSY_NEEDS_QUALIFY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_qualify));  // R6

  AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    data_latch |=> (lat_data == $past(din)));  // R5

  AST_BUSY_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(lat_addr));  // R12

endmodule

bind eeprom_write_engine eew_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready),
  .wr_qualify(wr_qualify), .data_latch(data_latch), .commit(commit),
  .lat_addr(lat_addr), .lat_data(lat_data), .din(din)
);

// File: tb/sim_eeprom_write_engine.sv
`timescale 1ns/1ps
module sim_eeprom_write_engine;

  localparam int AW   = 8;
  localparam int GM   = 3;
  localparam int FSTC = 16;
  localparam int SLWC = 40;
  localparam int CLRC = 60;
  localparam int WRC  = FSTC;
  localparam int WIN  = CLRC + 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          id_hv = 1'b0, clr_hv = 1'b0, vcc_low = 1'b0;
  logic [7:0]    dout;
  logic          dout_en, ready;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  eeprom_write_engine #(
    .ADDR_W(AW), .GLITCH_MIN(GM), .SLOW_CYCLES(SLWC), .FAST_CYCLES(FSTC),
    .FAST_VARIANT(1'b1), .CLEAR_CYCLES(CLRC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .id_hv(id_hv), .clr_hv(clr_hv), .vcc_low(vcc_low),
    .dout(dout), .dout_en(dout_en), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [5:0] p1, p2;        // {ce,oe,we,id,clr,vlow} seen one and two samples late
  bit         wl_prev;
  int         m_st, m_n;     // 0 idle, 1 counting low, 2 waiting for rise, 3 timing
  logic [AW-1:0] m_a;
  logic [7:0]    m_d;
  bit            m_idf, m_clr;
  logic [7:0]    m_main [256];
  logic [7:0]    m_id   [32];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_n = 0; wl_prev = 0;
      p1 = 6'b111000; p2 = 6'b111000;
      foreach (m_main[i]) m_main[i] = 8'hFF;
      foreach (m_id[i])   m_id[i]   = 8'hFF;
    end else begin
      bit wl;
      wl = !p2[5] && !p2[3];
      case (m_st)
        0: if (wl && !wl_prev && !p2[0] && (p2[4] || p2[1])) begin
             m_a = addr; m_idf = p2[2]; m_clr = p2[1]; m_n = 1;
             m_st = (GM <= 1) ? 2 : 1;
           end
        1: if (!wl) m_st = 0;
           else begin
             if (m_n + 1 >= GM) m_st = 2;
             m_n++;
           end
        2: if (!wl) begin m_d = din; m_n = 0; m_st = 3; end
        default: begin
          m_n++;
          if (m_n >= (m_clr ? CLRC : WRC)) begin
            if (m_clr) foreach (m_main[i]) m_main[i] = 8'hFF;
            else if (m_idf && m_a[7:5] == 3'b111) m_id[m_a[4:0]] = m_d;
            else m_main[m_a] = m_d;
            m_st = 0;
          end
        end
      endcase
      wl_prev = wl;
      p2 = p1;
      p1 = {ce_n, oe_n, we_n, id_hv, clr_hv, vcc_low};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit rd, rid, wid;
      logic [7:0] e;
      rd  = !p2[5] && !p2[4] && p2[3];
      rid = p2[2] && (addr[7:5] == 3'b111);
      wid = m_idf && (m_a[7:5] == 3'b111);
      if (!rd) e = 8'h00;
      else if (m_st == 3 && !m_clr && addr == m_a && rid == wid) e = {~m_d[7], 7'b0};
      else if (rid) e = m_id[addr[4:0]];
      else e = m_main[addr];
      chk(ready == (m_st < 2), "R4 model ready", int'(ready), int'(m_st < 2));
      chk(dout_en == rd, "R1 model dout_en", int'(dout_en), int'(rd));
      chk(dout == e, "R1 model dout", int'(dout), int'(e));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_late,
                          input logic [7:0] d, input int low, input bit oe_lvl,
                          input bit measure, output int busy);
    ce_n = 1'b0; oe_n = oe_lvl; we_n = 1'b1; addr = a_fall; din = ~d;
    tick(1);
    we_n = 1'b0;
    if (low >= 5) begin
      tick(4);
      addr = a_late; din = d;
      tick(low - 4);
    end else begin
      din = d;
      tick(low);
    end
    we_n = 1'b1;
    busy = 0;
    if (measure) begin
      for (int k = 0; k < WIN; k++) begin
        @(negedge clk);
        if (!ready) busy++;
      end
    end
    @(posedge clk); #1;
    ce_n = 1'b1; oe_n = 1'b1;
    tick(2);
  endtask

  task automatic read_byte(input logic [AW-1:0] a, output logic [7:0] v, output logic en);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    tick(3);
    @(negedge clk);
    v = dout; en = dout_en;
    @(posedge clk); #1;
    ce_n = 1'b1; oe_n = 1'b1;
    tick(1);
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (ready) break;
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int b;
    logic [7:0] v;
    logic en;

    tick(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R4 reset ready", int'(ready), 1);
    chk(dout_en == 1'b0, "R2 reset dout_en", int'(dout_en), 0);
    @(posedge clk); #1;

    read_byte(8'h10, v, en);
    chk(v == 8'hFF && en, "R1 erased read", int'(v), 'hFF);

    // address at fall, data at rise, fast write time
    do_write(8'h10, 8'h11, 8'hA5, 6, 1'b1, 1'b1, b);
    chk(b == WRC + 3, "R8 fast write busy length", b, WRC + 3);
    read_byte(8'h10, v, en);
    chk(v == 8'hA5, "R5 byte at fall address", int'(v), 'hA5);
    read_byte(8'h11, v, en);
    chk(v == 8'hFF, "R5 late address untouched", int'(v), 'hFF);

    // data polling
    do_write(8'h20, 8'h20, 8'h3C, 6, 1'b1, 1'b0, b);
    read_byte(8'h20, v, en);
    chk(v == 8'h80, "R7 poll during write", int'(v), 'h80);
    wait_ready();
    read_byte(8'h20, v, en);
    chk(v == 8'h3C, "R7 true byte after write", int'(v), 'h3C);

    // standby
    ce_n = 1'b1; oe_n = 1'b0; addr = 8'h10;
    tick(3);
    @(negedge clk);
    chk(dout_en == 1'b0 && dout == 8'h00, "R2 standby no drive", int'(dout), 0);
    @(posedge clk); #1; oe_n = 1'b1; tick(1);

    // OE low inhibits
    do_write(8'h40, 8'h40, 8'h55, 6, 1'b0, 1'b1, b);
    chk(b == 0, "R3 inhibit stays ready", b, 0);
    read_byte(8'h40, v, en);
    chk(v == 8'hFF, "R3 inhibit no change", int'(v), 'hFF);

    // glitch filter boundary
    do_write(8'h70, 8'h70, 8'h22, GM - 1, 1'b1, 1'b1, b);
    chk(b == 0, "R6 short pulse ignored", b, 0);
    read_byte(8'h70, v, en);
    chk(v == 8'hFF, "R6 short pulse no change", int'(v), 'hFF);
    do_write(8'h71, 8'h71, 8'h33, GM, 1'b1, 1'b1, b);
    chk(b == WRC + 1, "R6 minimum pulse writes", b, WRC + 1);
    read_byte(8'h71, v, en);
    chk(v == 8'h33, "R6 minimum pulse data", int'(v), 'h33);

    // strobe while busy is ignored
    do_write(8'h50, 8'h50, 8'h77, 6, 1'b1, 1'b0, b);
    do_write(8'h51, 8'h51, 8'h99, 6, 1'b1, 1'b0, b);
    wait_ready();
    read_byte(8'h50, v, en);
    chk(v == 8'h77, "R12 running write completes", int'(v), 'h77);
    read_byte(8'h51, v, en);
    chk(v == 8'hFF, "R12 busy strobe ignored", int'(v), 'hFF);

    // undervoltage
    vcc_low = 1'b1; tick(3);
    do_write(8'h60, 8'h60, 8'h11, 6, 1'b1, 1'b1, b);
    chk(b == 0, "R11 undervoltage no busy", b, 0);
    vcc_low = 1'b0; tick(3);
    read_byte(8'h60, v, en);
    chk(v == 8'hFF, "R11 undervoltage no change", int'(v), 'hFF);

    // identification row
    id_hv = 1'b1; tick(3);
    do_write(8'hE3, 8'hE3, 8'h5A, 6, 1'b1, 1'b1, b);
    chk(b == WRC + 3, "R9 row write busy", b, WRC + 3);
    read_byte(8'hE3, v, en);
    chk(v == 8'h5A, "R9 row readback", int'(v), 'h5A);
    id_hv = 1'b0; tick(3);
    read_byte(8'hE3, v, en);
    chk(v == 8'hFF, "R9 main array behind row", int'(v), 'hFF);

    // whole-array clear
    clr_hv = 1'b1; tick(3);
    do_write(8'h00, 8'h00, 8'h00, 6, 1'b1, 1'b1, b);
    chk(b == CLRC + 3, "R10 clear busy length", b, CLRC + 3);
    clr_hv = 1'b0; tick(3);
    read_byte(8'h10, v, en);
    chk(v == 8'hFF, "R10 main cleared 0x10", int'(v), 'hFF);
    read_byte(8'h20, v, en);
    chk(v == 8'hFF, "R10 main cleared 0x20", int'(v), 'hFF);
    id_hv = 1'b1; tick(3);
    read_byte(8'hE3, v, en);
    chk(v == 8'h5A, "R10 row kept", int'(v), 'h5A);
    id_hv = 1'b0; tick(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule